// File: doc/BRIEF.md
# Command Mailbox Register with Busy Interlock and Soft-Reset Launcher

A 32-bit register through which a host hands one command at a time to a command-processing engine. The host writes the command fields together with a busy flag. The register then decodes the word into an opcode, a page number, a unit select and a channel number, and fires a one-cycle start pulse toward the engine. The engine signals completion through a done strobe, which clears the busy flag. While the flag is set, ordinary writes are refused, so the engine always sees a stable command.

A write with the reset bit set skips the busy interlock. The reset bit reads back set for one cycle, and then both the reset bit and the busy flag clear. The write also launches a 60-cycle background routine that drives a reset line to the channel blocks. The host does not have to wait for that routine to finish before issuing new commands.

Top module: `cmd_mailbox_reg`

## Requirements
- R1: After the asynchronous reset, the readback word is zero, and cmd_busy, cmd_start, chan_reset and reset_busy are all low.
- R2: Word layout, with LSB = bit 0: reset bit 31, page 30:26, unit 25:21, busy flag 16, channel 15:6, opcode 3:0. Reserved bits 20:17 and 5:4 read zero.
- R3: A write with bit 31 clear and bit 16 set, made while the flag is clear, produces a single-cycle cmd_start in the cycle after the write edge. In that cycle the decoded opcode, page, unit and channel match the written word.
- R4: A write with bit 31 clear, made while the flag is set, is ignored: the readback does not change and no start pulse occurs.
- R5: cmd_done asserted while the flag is set clears the flag at the next edge.
- R6: cmd_done asserted while the flag is clear has no effect on the readback.
- R7: A write with bit 31 set is accepted whatever the flag state. In the next cycle the reset bit and the written flag value read back, the command fields read zero and there is no start pulse. One cycle later both the reset bit and the flag read clear.
- R8: chan_reset is high for exactly 60 consecutive cycles, beginning two cycles after the reset write. reset_busy covers the pending reset cycle and the whole routine.
- R9: Commands written while chan_reset is high are accepted normally.
- R10: A write with bits 31 and 16 clear, made while the flag is clear, updates the fields without a start pulse.
- R11: A command that is pending when a reset is accepted is abandoned. A later cmd_done does not disturb the readback, and the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Register readback |
| cmd_busy | output | 1 | Busy flag |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_opcode | output | 4 | Latched opcode |
| cmd_page | output | 5 | Latched page number |
| cmd_unit | output | 5 | Latched unit select |
| cmd_chan | output | 10 | Latched channel number |
| cmd_done | input | 1 | Engine completion strobe |
| chan_reset | output | 1 | Reset to channel blocks during routine |
| reset_busy | output | 1 | Reset pending or routine running |

## Verification
The hardest case to reach is a reset that arrives on top of a command the engine has not yet finished. The routine must still run its full length while fresh commands flow through it. To reach this, the bench leaves a command pending, fires the reset write, and then sends a stray done strobe. It then issues a new command partway through the routine while it counts the chan_reset cycles at the ports.

// File: rtl/cmdmb_pkg.sv
package cmdmb_pkg;
  localparam int WORD_W   = 32;
  localparam int RST_B    = 31;
  localparam int PAGE_LSB = 26;
  localparam int PAGE_W   = 5;
  localparam int UNIT_LSB = 21;
  localparam int UNIT_W   = 5;
  localparam int FLG_B    = 16;
  localparam int CHAN_LSB = 6;
  localparam int CHAN_W   = 10;
  localparam int OP_LSB   = 0;
  localparam int OP_W     = 4;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [PAGE_W-1:0] page;
    logic [UNIT_W-1:0] unit;
    logic [CHAN_W-1:0] chan;
  } cmd_t;

  function automatic logic [WORD_W-1:0] pack_word(input logic rst, input logic flg, input cmd_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RST_B] = rst;
    w[FLG_B] = flg;
    w[PAGE_LSB +: PAGE_W] = c.page;
    w[UNIT_LSB +: UNIT_W] = c.unit;
    w[CHAN_LSB +: CHAN_W] = c.chan;
    w[OP_LSB +: OP_W]     = c.op;
    return w;
  endfunction
endpackage

// File: rtl/cmdmb_wdec.sv
module cmdmb_wdec
  import cmdmb_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  output logic              w_rst,
  output logic              w_flg,
  output cmd_t              w_cmd
);
  always_comb begin
    w_rst      = wdata[RST_B];
    w_flg      = wdata[FLG_B];
    w_cmd.page = wdata[PAGE_LSB +: PAGE_W];
    w_cmd.unit = wdata[UNIT_LSB +: UNIT_W];
    w_cmd.chan = wdata[CHAN_LSB +: CHAN_W];
    w_cmd.op   = wdata[OP_LSB +: OP_W];
  end
endmodule

// File: rtl/cmdmb_ctrl.sv
module cmdmb_ctrl
  import cmdmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic w_rst,
  input  logic w_flg,
  input  cmd_t w_cmd,
  input  logic cmd_done,
  output cmd_t cmd_q,
  output logic flg_q,
  output logic rst_q,
  output logic start_q
);
  logic acc_rst, acc_cmd, cmd_en;
  logic flg_d, rst_d, start_d;
  cmd_t cmd_d;

  assign acc_rst = host_wr & w_rst;
  assign acc_cmd = host_wr & ~w_rst & ~flg_q & ~rst_q;
  assign cmd_en  = acc_rst | acc_cmd;

  always_comb begin
    cmd_d   = cmd_q;
    flg_d   = flg_q;
    rst_d   = 1'b0;
    start_d = 1'b0;
    if (rst_q)            flg_d = 1'b0;
    if (flg_q && cmd_done) flg_d = 1'b0;
    if (acc_rst) begin
      rst_d = 1'b1;
      flg_d = w_flg;
      cmd_d = '0;
    end else if (acc_cmd) begin
      cmd_d   = w_cmd;
      flg_d   = w_flg;
      start_d = w_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      flg_q   <= 1'b0;
      rst_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      flg_q   <= flg_d;
      rst_q   <= rst_d;
      start_q <= start_d;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R3
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(!flg_q)); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q && host_wr && !w_rst) |=> $stable(cmd_q)); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q && cmd_done && !(host_wr && w_rst)) |=> !flg_q); // R5
  AST_RST_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !(host_wr && w_rst)) |=> (!rst_q && !flg_q)); // R7
endmodule

// File: rtl/cmdmb_rst_seq.sv
module cmdmb_rst_seq #(
  parameter int SEQ_LEN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic active
);
  localparam int CW = $clog2(SEQ_LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(SEQ_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = kick | active;

  always_comb begin
    if (kick) cnt_d = LEN_V;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == LEN_V)); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !kick) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/cmd_mailbox_reg.sv
module cmd_mailbox_reg
  import cmdmb_pkg::*;
#(
  parameter int SEQ_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              cmd_busy,
  output logic              cmd_start,
  output logic [OP_W-1:0]   cmd_opcode,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [UNIT_W-1:0] cmd_unit,
  output logic [CHAN_W-1:0] cmd_chan,
  input  logic              cmd_done,
  output logic              chan_reset,
  output logic              reset_busy
);
  logic w_rst, w_flg, flg_q, rst_q, start_q, seq_active;
  cmd_t w_cmd, cmd_q;

  cmdmb_wdec u_wdec (
    .wdata (host_wdata),
    .w_rst (w_rst),
    .w_flg (w_flg),
    .w_cmd (w_cmd)
  );

  cmdmb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (host_wr),
    .w_rst    (w_rst),
    .w_flg    (w_flg),
    .w_cmd    (w_cmd),
    .cmd_done (cmd_done),
    .cmd_q    (cmd_q),
    .flg_q    (flg_q),
    .rst_q    (rst_q),
    .start_q  (start_q)
  );

  cmdmb_rst_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (rst_q),
    .active (seq_active)
  );

  assign host_rdata = pack_word(rst_q, flg_q, cmd_q);
  assign cmd_busy   = flg_q;
  assign cmd_start  = start_q;
  assign cmd_opcode = cmd_q.op;
  assign cmd_page   = cmd_q.page;
  assign cmd_unit   = cmd_q.unit;
  assign cmd_chan   = cmd_q.chan;
  assign chan_reset = seq_active;
  assign reset_busy = rst_q | seq_active;

  AST_NO_START_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !cmd_start); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[20:17] == '0) && (host_rdata[5:4] == '0)); // R2
endmodule

// File: tb/test_cmd_mailbox_reg.sv
module test_cmd_mailbox_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        cmd_busy, cmd_start, cmd_done, chan_reset, reset_busy;
  logic [3:0]  cmd_opcode;
  logic [4:0]  cmd_page, cmd_unit;
  logic [9:0]  cmd_chan;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cmd_mailbox_reg i_cmd_mailbox_reg (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cmd_busy(cmd_busy), .cmd_start(cmd_start),
    .cmd_opcode(cmd_opcode), .cmd_page(cmd_page), .cmd_unit(cmd_unit),
    .cmd_chan(cmd_chan), .cmd_done(cmd_done), .chan_reset(chan_reset),
    .reset_busy(reset_busy)
  );

  // {wr, wdata, done, expected rdata, expected start}
  localparam logic [66:0] VECS [8] = '{
    {1'b1, 32'h0CA10A89, 1'b0, 32'h0CA10A89, 1'b1},  // R3 launch
    {1'b0, 32'h00000000, 1'b0, 32'h0CA10A89, 1'b0},  // R3 pulse ends
    {1'b1, 32'h0001000F, 1'b0, 32'h0CA10A89, 1'b0},  // R4 refused
    {1'b0, 32'h00000000, 1'b1, 32'h0CA00A89, 1'b0},  // R5 done clears
    {1'b0, 32'h00000000, 1'b1, 32'h0CA00A89, 1'b0},  // R6 stray done
    {1'b1, 32'h7FFFFFFF, 1'b0, 32'h7FE1FFCF, 1'b1},  // R2 reserved zero
    {1'b0, 32'h00000000, 1'b1, 32'h7FE0FFCF, 1'b0},  // R5
    {1'b1, 32'h04000003, 1'b0, 32'h04000003, 1'b0}   // R10 no start
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    int guard;
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = '0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", host_rdata, 32'h0);
    chk("R1 flags", {28'h0, cmd_busy, cmd_start, chan_reset, reset_busy}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      host_wr    = VECS[i][66];
      host_wdata = VECS[i][65:34];
      cmd_done   = VECS[i][33];
      step();
      chk($sformatf("R2-table rdata v%0d", i), host_rdata, VECS[i][32:1]);
      chk($sformatf("R3-table start v%0d", i), {31'h0, cmd_start}, {31'h0, VECS[i][0]});
    end
    host_wr = 1'b0; cmd_done = 1'b0;

    // R3 decoded fields during start
    host_wr = 1'b1; host_wdata = 32'h0CA10A89;
    step();
    host_wr = 1'b0;
    chk("R3 start", {31'h0, cmd_start}, 32'h1);
    chk("R3 fields", {12'h0, cmd_opcode, cmd_page, cmd_unit, cmd_chan}, {12'h0, 4'h9, 5'd3, 5'd5, 10'h2A});

    // R7 reset write over pending command
    host_wr = 1'b1; host_wdata = 32'h80010000;
    step();
    host_wr = 1'b0;
    chk("R7 rst readback", host_rdata, 32'h80010000);
    chk("R7 no start", {31'h0, cmd_start}, 32'h0);
    chk("R8 reset_busy pending", {30'h0, reset_busy, chan_reset}, 32'h2);
    step();
    chk("R7 self clear", host_rdata, 32'h0);
    chk("R8 chan_reset on", {31'h0, chan_reset}, 32'h1);
    cnt = chan_reset ? 1 : 0;

    // R11 stray done after abandon
    cmd_done = 1'b1;
    step();
    cmd_done = 1'b0;
    if (chan_reset) cnt++;
    chk("R11 abandoned", host_rdata, 32'h0);

    // R9 command during routine
    host_wr = 1'b1; host_wdata = 32'h0CA10A89;
    step();
    host_wr = 1'b0;
    if (chan_reset) cnt++;
    chk("R9 start in routine", {31'h0, cmd_start}, 32'h1);
    chk("R9 readback", host_rdata, 32'h0CA10A89);

    cmd_done = 1'b1;
    guard = 0;
    while (chan_reset && guard < 100) begin
      step();
      cmd_done = 1'b0;
      if (chan_reset) cnt++;
      guard++;
    end
    chk("R8 length", cnt, 60);
    chk("R8 reset_busy off", {31'h0, reset_busy}, 32'h0);
    chk("R11 next cmd done", host_rdata, 32'h0CA00A89);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule